// File: doc/BRIEF.md
# Weighted Five-Agent Memory Port Arbiter

This block decides which of five requesters may issue commands on a single shared memory command port. Each requester owns three settings: a cap on how many commands it may issue in one tenure, an aging period after which a waiting requester is promoted above the others, and a floor on how many commands it is allowed to issue before the port can be handed to someone else while others are waiting. Together these settings give each requester its share of the port, in place of a plain rotation.

Settings are written indirectly. A select register is written first. A data strobe for one of the three settings then stores the data word into the requester whose index times that setting's field width equals the select value. The grant is held in registers and is presented as a one-hot vector, a valid flag and a binary index. A grant moves only when a command is accepted or when the holder withdraws its request.

Top module: `mem_port_arbiter`

## Requirements
- R1: After reset no grant is asserted, `gnt_idx` is 0, and the settings are cap {31,31,31,4,4}, aging period 255 for every agent, and floor {4,16,16,4,4} for agents 0 to 4. The round-robin pointer starts so that agent 0 is searched first.
- R2: `gnt` is one-hot or zero, `gnt_valid` is high exactly when `gnt` is non-zero, and `gnt_idx` is the index of the set bit. `gnt_idx` is 0 when there is no grant. With no request, no grant is asserted.
- R3: A request seen at a clock edge while the port is free is granted from that edge, so the grant is visible one cycle later. While the holder keeps requesting, its grant does not change in cycles without `cmd_accept`.
- R4: The holder keeps the port until its accepted-command count in the current tenure reaches its floor. It then releases at that accept if another agent is requesting. If no other agent is requesting, it keeps the port beyond the floor, up to the cap.
- R5: The holder releases at the accept that brings its count to its cap, even when the count is still below the floor. A cap of 0 is treated as 1.
- R6: When the holder drops its request, the port is released at the next edge and re-arbitrated among the remaining requesters in the same edge.
- R7: Among candidates of equal priority, the winner is the first requesting agent found after the last granted agent, in increasing index order with wrap-around.
- R8: An agent that has requested without a grant for 4×P consecutive clocks, where P is its aging period, becomes urgent. Urgent agents are chosen before non-urgent ones, round-robin among themselves. The aging timer reloads while the agent is granted or idle. P = 0 disables aging.
- R9: The select register takes `cfg_sel_data` on `cfg_sel_we`. A write with `cfg_lim_we` stores `cfg_data[4:0]` into agent k when select = 5k. A write with `cfg_prd_we` or `cfg_acpt_we` stores `cfg_data[7:0]` into agent k when select = 8k.
- R10: A data write whose select value is not an exact multiple of that field's width, or that maps to an agent index of 5 or more, changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel_we | input | 1 | Write strobe for the select register |
| cfg_sel_data | input | 8 | Select value |
| cfg_lim_we | input | 1 | Store cfg_data as a command cap |
| cfg_prd_we | input | 1 | Store cfg_data as an aging period |
| cfg_acpt_we | input | 1 | Store cfg_data as a command floor |
| cfg_data | input | 8 | Setting data |
| req | input | 5 | Per-agent request |
| cmd_accept | input | 1 | The port accepted one command from the holder |
| gnt | output | 5 | One-hot grant |
| gnt_valid | output | 1 | A grant is asserted |
| gnt_idx | output | 3 | Index of the granted agent |

## Verification
The hardest situation to reach is aging that overrides the rotation. This needs one agent holding the port long enough for a waiting agent's timer to run out, and rotation alone must favour a different waiting agent. The bench holds agent 0 without accepts while agents 1 and 4 wait. Agent 4 is given a short period and agent 1 has aging disabled. After the floor's worth of accepts, agent 4 must win. A control run with the default long period shows agent 1 winning instead. Indirect writes with misaligned and out-of-range select values are checked through the release point they would have moved.

// File: rtl/arb_pkg.sv
// Package: reset-time settings shared by the arbiter's configuration store.
// Assumes agents beyond index 4 take the settings of agent 4.
package arb_pkg;

    // Reset cap (commands per tenure) for agent i.
    function automatic logic [7:0] dflt_cap(input int i);
        if (i < 3) return 8'h1F;
        return 8'h04;
    endfunction

    // Reset aging period (units of four clocks) for agent i.
    function automatic logic [7:0] dflt_period(input int i);
        if (i < 0) return 8'h00;
        return 8'hFF;
    endfunction

    // Reset floor (commands before yielding) for agent i.
    function automatic logic [7:0] dflt_floor(input int i);
        if (i == 1 || i == 2) return 8'h10;
        return 8'h04;
    endfunction

endpackage

// File: rtl/arb_cfg_regs.sv
// Indirect settings store: a select register plus three data strobes.
// A data strobe updates agent k only when select equals k * field width.
// Assumes each field width is no wider than the data word.
module arb_cfg_regs
    import arb_pkg::*;
#(
    parameter int N      = 5,
    parameter int LIM_W  = 5,
    parameter int PRD_W  = 8,
    parameter int ACPT_W = 8,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [CFG_W-1:0]  sel_data,
    input  logic              lim_we,
    input  logic              prd_we,
    input  logic              acpt_we,
    input  logic [CFG_W-1:0]  wdata,
    output logic [LIM_W-1:0]  lim_o  [N],
    output logic [PRD_W-1:0]  prd_o  [N],
    output logic [ACPT_W-1:0] acpt_o [N]
);

    logic [CFG_W-1:0] sel_q;

    // Holds the select value for the following data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (sel_we) sel_q <= sel_data;
    end

    for (genvar g = 0; g < N; g++) begin : g_agent
        localparam logic [CFG_W-1:0] LIM_SEL  = CFG_W'(g * LIM_W);
        localparam logic [CFG_W-1:0] PRD_SEL  = CFG_W'(g * PRD_W);
        localparam logic [CFG_W-1:0] ACPT_SEL = CFG_W'(g * ACPT_W);

        logic hit_lim, hit_prd, hit_acpt;
        assign hit_lim  = lim_we  && (sel_q == LIM_SEL);
        assign hit_prd  = prd_we  && (sel_q == PRD_SEL);
        assign hit_acpt = acpt_we && (sel_q == ACPT_SEL);

        // Stores the cap of this agent.
        always_ff @(posedge clk) begin
            if (!rst_n) lim_o[g] <= LIM_W'(dflt_cap(g));
            else if (hit_lim) lim_o[g] <= wdata[LIM_W-1:0];
        end

        // Stores the aging period of this agent.
        always_ff @(posedge clk) begin
            if (!rst_n) prd_o[g] <= PRD_W'(dflt_period(g));
            else if (hit_prd) prd_o[g] <= wdata[PRD_W-1:0];
        end

        // Stores the floor of this agent.
        always_ff @(posedge clk) begin
            if (!rst_n) acpt_o[g] <= ACPT_W'(dflt_floor(g));
            else if (hit_acpt) acpt_o[g] <= wdata[ACPT_W-1:0];
        end
    end

endmodule

// File: rtl/arb_age_timer.sv
// Aging timer of one agent: counts clocks spent requesting without a grant
// and flags the agent urgent after 4 * period clocks.
// Assumes period 0 means aging is off.
module arb_age_timer #(
    parameter int PRD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             granted_i,
    input  logic [PRD_W-1:0] prd_i,
    output logic             urgent_o
);

    localparam int CNT_W = PRD_W + 2;

    logic [CNT_W-1:0] cnt_q;

    // Reloads while idle or granted, otherwise counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else if (!req_i || granted_i) cnt_q <= {prd_i, 2'b00};
        else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end

    assign urgent_o = req_i && !granted_i && (cnt_q == '0) && (prd_i != '0);

endmodule

// File: rtl/arb_rr_pick.sv
// Rotating picker: returns the first set bit after the given position,
// in increasing index order with wrap-around. Purely combinational.
module arb_rr_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     cand_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scans the N positions that follow the last winner.
    always_comb begin
        int unsigned pos;
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 1; k <= N; k++) begin
            pos = (int'(last_i) + k) % N;
            if (!found_o && cand_i[pos]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/arb_tenure.sv
// Tenure tracker: holds the current owner, counts its accepted commands and
// decides when the port is released and re-arbitrated.
// Assumes the cap field is no wider than the floor field.
module arb_tenure #(
    parameter int N      = 5,
    parameter int IDX_W  = 3,
    parameter int LIM_W  = 5,
    parameter int ACPT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_i,
    input  logic              accept_i,
    input  logic [LIM_W-1:0]  lim_i,
    input  logic [ACPT_W-1:0] acpt_i,
    input  logic              pick_found_i,
    input  logic [IDX_W-1:0]  pick_idx_i,
    output logic              valid_o,
    output logic [IDX_W-1:0]  owner_o,
    output logic [IDX_W-1:0]  last_o
);

    localparam int CNT_W = ACPT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cap;
    logic [N-1:0]     owner_mask;
    logic             owner_req, others_req, hit_cap, hit_floor;
    logic             release_c, choose_c;

    assign cnt_inc    = cnt_q + CNT_W'(1);
    assign cap        = (lim_i == '0) ? CNT_W'(1) : CNT_W'(lim_i);
    assign owner_mask = N'(1) << owner_o;
    assign owner_req  = |(req_i & owner_mask);
    assign others_req = |(req_i & ~owner_mask);
    assign hit_cap    = cnt_inc >= cap;
    assign hit_floor  = cnt_inc >= CNT_W'(acpt_i);

    // Release on withdrawal, or at an accept that reaches cap or floor-with-contention.
    assign release_c = valid_o &&
                       (!owner_req || (accept_i && (hit_cap || (hit_floor && others_req))));
    assign choose_c  = !valid_o || release_c;

    // Updates owner, round-robin pointer and tenure count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            owner_o <= '0;
            last_o  <= IDX_W'(N - 1);
            cnt_q   <= '0;
        end else if (choose_c) begin
            valid_o <= pick_found_i;
            owner_o <= pick_found_i ? pick_idx_i : '0;
            cnt_q   <= '0;
            if (pick_found_i) last_o <= pick_idx_i;
        end else if (accept_i && cnt_q != '1) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/mem_port_arbiter.sv
// Top: arbitrates one memory command port among N agents using per-agent
// cap, floor and aging settings written through an indirect select register.
// Assumes cmd_accept is only meaningful while a grant is asserted.
module mem_port_arbiter #(
    parameter int N      = 5,
    parameter int LIM_W  = 5,
    parameter int PRD_W  = 8,
    parameter int ACPT_W = 8,
    parameter int CFG_W  = 8,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sel_we,
    input  logic [CFG_W-1:0] cfg_sel_data,
    input  logic             cfg_lim_we,
    input  logic             cfg_prd_we,
    input  logic             cfg_acpt_we,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [N-1:0]     req,
    input  logic             cmd_accept,
    output logic [N-1:0]     gnt,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [LIM_W-1:0]  lim_all  [N];
    logic [PRD_W-1:0]  prd_all  [N];
    logic [ACPT_W-1:0] acpt_all [N];
    logic [N-1:0]      urgent;
    logic [N-1:0]      cand;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  owner;
    logic [IDX_W-1:0]  last_idx;
    logic              valid;

    arb_cfg_regs #(
        .N(N), .LIM_W(LIM_W), .PRD_W(PRD_W), .ACPT_W(ACPT_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (cfg_sel_we),
        .sel_data(cfg_sel_data),
        .lim_we  (cfg_lim_we),
        .prd_we  (cfg_prd_we),
        .acpt_we (cfg_acpt_we),
        .wdata   (cfg_data),
        .lim_o   (lim_all),
        .prd_o   (prd_all),
        .acpt_o  (acpt_all)
    );

    for (genvar g = 0; g < N; g++) begin : g_age
        arb_age_timer #(.PRD_W(PRD_W)) u_age (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req[g]),
            .granted_i(gnt[g]),
            .prd_i    (prd_all[g]),
            .urgent_o (urgent[g])
        );
    end

    // Urgent requesters form the candidate set when any exist.
    assign cand = (|(req & urgent)) ? (req & urgent) : req;

    arb_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .cand_i (cand),
        .last_i (last_idx),
        .found_o(pick_found),
        .idx_o  (pick_idx)
    );

    arb_tenure #(
        .N(N), .IDX_W(IDX_W), .LIM_W(LIM_W), .ACPT_W(ACPT_W)
    ) u_ten (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .accept_i    (cmd_accept),
        .lim_i       (lim_all[owner]),
        .acpt_i      (acpt_all[owner]),
        .pick_found_i(pick_found),
        .pick_idx_i  (pick_idx),
        .valid_o     (valid),
        .owner_o     (owner),
        .last_o      (last_idx)
    );

    assign gnt       = valid ? (N'(1) << owner) : '0;
    assign gnt_valid = valid;
    assign gnt_idx   = owner;

endmodule

// File: rtl/mem_port_arbiter_chk.sv
// Checker: port-level properties of the arbiter, bound to every instance.
module mem_port_arbiter_chk #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic             cmd_accept,
    input logic [N-1:0]     gnt,
    input logic             gnt_valid,
    input logic [IDX_W-1:0] gnt_idx
);

    // R2: grant is one-hot or zero.
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R2: valid flag and index agree with the vector.
    a_r2_valid_idx: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid == (gnt != '0) && (gnt_valid ? gnt[gnt_idx] : (gnt_idx == '0)));

    // R2: no request means no grant at the next edge.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !gnt_valid);

    // R3: a free port with a request is granted at the next edge.
    a_r3_grant_soon: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && req != '0) |=> gnt_valid);

    // R3: holder still requesting and no accept keeps the grant.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && req[gnt_idx] && !cmd_accept) |=> (gnt_valid && $stable(gnt)));

    // R6: a holder that withdraws loses the grant at the next edge.
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !req[gnt_idx]) |=> ((gnt & $past(gnt)) == '0));

endmodule

bind mem_port_arbiter mem_port_arbiter_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cmd_accept(cmd_accept),
    .gnt       (gnt),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
);

// File: tb/mem_port_arbiter_test.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled
// on the falling edge.
module mem_port_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_sel_we, cfg_lim_we, cfg_prd_we, cfg_acpt_we;
    logic [7:0] cfg_sel_data, cfg_data;
    logic [4:0] req;
    logic       cmd_accept;
    logic [4:0] gnt;
    logic       gnt_valid;
    logic [2:0] gnt_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_port_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel_we(cfg_sel_we), .cfg_sel_data(cfg_sel_data),
        .cfg_lim_we(cfg_lim_we), .cfg_prd_we(cfg_prd_we), .cfg_acpt_we(cfg_acpt_we),
        .cfg_data(cfg_data), .req(req), .cmd_accept(cmd_accept),
        .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    task automatic check(input string tag, input logic [4:0] exp);
        logic [2:0] exp_idx;
        exp_idx = '0;
        for (int i = 0; i < 5; i++) if (exp[i]) exp_idx = 3'(i);
        n_checks++;
        if (gnt !== exp || gnt_valid !== (exp != '0) || gnt_idx !== exp_idx) begin
            n_fail++;
            $display("FAIL %s: gnt=%b valid=%b idx=%0d, expected gnt=%b valid=%b idx=%0d",
                     tag, gnt, gnt_valid, gnt_idx, exp, exp != '0, exp_idx);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; cmd_accept = 1'b0;
        cfg_sel_we = 1'b0; cfg_lim_we = 1'b0; cfg_prd_we = 1'b0; cfg_acpt_we = 1'b0;
        cfg_sel_data = '0; cfg_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind: 0 cap, 1 period, 2 floor
    task automatic wr(input int kind, input logic [7:0] sel, input logic [7:0] data);
        cfg_sel_we = 1'b1; cfg_sel_data = sel;
        @(negedge clk);
        cfg_sel_we = 1'b0; cfg_data = data;
        cfg_lim_we = (kind == 0); cfg_prd_we = (kind == 1); cfg_acpt_we = (kind == 2);
        @(negedge clk);
        cfg_lim_we = 1'b0; cfg_prd_we = 1'b0; cfg_acpt_we = 1'b0;
    endtask

    task automatic accept(input int n);
        repeat (n) begin
            cmd_accept = 1'b1;
            @(negedge clk);
            cmd_accept = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; req = 5'b11111;
        @(negedge clk);
        check("R1 grant during reset", 5'b00000);
        do_reset();
        @(negedge clk);
        check("R1 grant after reset", 5'b00000);
    endtask

    task automatic t_defaults();
        do_reset();
        req = 5'b00011;
        @(negedge clk);
        check("R3 first grant after one edge", 5'b00001);
        repeat (4) @(negedge clk);
        check("R3 hold without accepts", 5'b00001);
        accept(3);
        check("R4 below default floor of 4", 5'b00001);
        accept(1);
        check("R1 default floor 4 then handoff", 5'b00010);
    endtask

    task automatic t_idle();
        do_reset();
        repeat (3) @(negedge clk);
        check("R2 no request no grant", 5'b00000);
        req = 5'b00100;
        @(negedge clk);
        check("R2 single request", 5'b00100);
        req = 5'b00000;
        @(negedge clk);
        check("R2 grant gone with requests", 5'b00000);
    endtask

    task automatic t_drop();
        do_reset();
        req = 5'b00100;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R3 held by lone requester", 5'b00100);
        req = 5'b01000;
        @(negedge clk);
        check("R6 withdrawal hands over", 5'b01000);
    endtask

    task automatic t_alone();
        do_reset();
        req = 5'b00001;
        @(negedge clk);
        accept(6);
        check("R4 no contender keeps port past floor", 5'b00001);
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int a = 0; a < 5; a++) wr(2, 8'(a * 8), 8'd1);
        req = 5'b11111;
        @(negedge clk);
        check("R7 rotation start agent 0", 5'b00001);
        accept(1); check("R7 rotation to 1", 5'b00010);
        accept(1); check("R7 rotation to 2", 5'b00100);
        accept(1); check("R7 rotation to 3", 5'b01000);
        accept(1); check("R7 rotation to 4", 5'b10000);
        accept(1); check("R7 rotation wraps to 0", 5'b00001);
        req = 5'b01010;
        @(negedge clk);
        check("R7 sparse after 0 picks 1", 5'b00010);
        accept(1); check("R7 sparse to 3", 5'b01000);
        accept(1); check("R7 sparse wraps to 1", 5'b00010);
    endtask

    task automatic t_indirect();
        do_reset();
        wr(2, 8'd16, 8'd2);
        req = 5'b01100;
        @(negedge clk);
        check("R9 agent 2 granted", 5'b00100);
        accept(1);
        check("R9 agent 2 below written floor", 5'b00100);
        accept(1);
        check("R9 floor 2 via select 16", 5'b01000);
    endtask

    task automatic t_cap();
        do_reset();
        wr(0, 8'd5, 8'd2);
        req = 5'b00110;
        @(negedge clk);
        accept(1);
        check("R5 below cap 2", 5'b00010);
        accept(1);
        check("R5 cap overrides floor 16", 5'b00100);
        do_reset();
        wr(0, 8'd15, 8'd0);
        req = 5'b11000;
        @(negedge clk);
        check("R5 agent 3 granted", 5'b01000);
        accept(1);
        check("R5 cap 0 acts as 1", 5'b10000);
    endtask

    task automatic t_ignored();
        do_reset();
        wr(2, 8'd1, 8'd1);
        wr(2, 8'd40, 8'd1);
        wr(0, 8'd1, 8'd1);
        wr(0, 8'd25, 8'd1);
        req = 5'b00011;
        @(negedge clk);
        accept(1);
        check("R10 misaligned select left floor", 5'b00001);
        accept(3);
        check("R10 default floor still 4", 5'b00010);
    endtask

    task automatic t_aging(input logic short_period, input logic [4:0] exp, input string tag);
        do_reset();
        wr(1, 8'd8, 8'd0);
        if (short_period) wr(1, 8'd32, 8'd2);
        req = 5'b00001;
        @(negedge clk);
        req = 5'b10011;
        repeat (12) @(negedge clk);
        check("R8 holder kept while others age", 5'b00001);
        accept(4);
        check(tag, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; cmd_accept = 1'b0;
        cfg_sel_we = 1'b0; cfg_lim_we = 1'b0; cfg_prd_we = 1'b0; cfg_acpt_we = 1'b0;
        cfg_sel_data = '0; cfg_data = '0;
        t_reset_state();
        t_defaults();
        t_idle();
        t_drop();
        t_alone();
        t_round_robin();
        t_indirect();
        t_cap();
        t_ignored();
        t_aging(1'b1, 5'b10000, "R8 aged agent 4 beats rotation");
        t_aging(1'b0, 5'b00010, "R8 long period leaves rotation order");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule